// File: doc/BRIEF.md
# Windowed PWM DAC Modulator

This block converts a stream of 10-bit unsigned waveform samples into one PWM bit. An external RC low-pass filter turns that bit into an analog voltage. The duty cycle is not spread over the full 0–100 % range. It is confined to a window of roughly 15 % to 91 % of each period. On a 3.3 V rail, the filtered level therefore stays between about 0.5 V and 3.0 V, and mid-scale sits near 1.75 V.

The period is 1024 cycles of the fast clock, which gives about 187.5 kHz at 192 MHz. A free-running counter marks the periods. The modulator takes a new sample only when the counter passes from 1023 back to 0. It maps that sample affinely into the duty window and drives the output high for the first part of every period. A one-cycle strobe marks each period start, so an upstream sample source can align to it.

Top module: `pwmw_dac`

## Requirements
- R1: For a latched sample s, the number of high cycles in a period equals 155 + floor(s × 776 / 1023).
- R2: A period is exactly 1024 clock cycles; the internal counter runs 0,1,…,1023 and wraps to 0.
- R3: Code 0 gives 155 high cycles and code 1023 gives 931 high cycles; the duty never leaves the range 155..931.
- R4: The sample input is captured only in the clock cycle in which the counter is 1023. A change at any other time has no effect on the pulse currently being produced. A value present in the counter-1023 cycle sets the next period.
- R5: Within a period, the output is high while the counter is below the duty count and low for the rest of the period, forming a single pulse that starts at the period start. The output comes from a register.
- R6: `period_start_o` is high for exactly one cycle per period, the cycle in which the counter is 0.
- R7: While `rst_n` is low, the counter is 0, the duty is the mid-scale value 543 (code 512), and both `pwm_o` and `period_start_o` are high. The first period after release has 543 high cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast PWM clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_i | input | 10 | Unsigned waveform sample |
| pwm_o | output | 1 | Registered PWM bit to the external RC filter |
| period_start_o | output | 1 | One-cycle pulse in the first cycle of each period |

## Verification
Most internal faults show up within one period of 1024 cycles as a wrong count of high cycles. A counter that skips or sticks moves the strobe away from a 1024-cycle spacing. A bad scaling product shifts the count away from 155 + s·776/1023, and the error is clearest at codes 0, 1, 512 and 1023. A duty register that reloads at the wrong time shows up as a pulse width that changes in the middle of a period, or as a sample that takes effect one period early or late. The bench therefore checks every cycle of each period, not only the total count.

// File: rtl/pwmw_pkg.sv
// Shared constants of the windowed PWM modulator.
// Assumes an unsigned sample and a power-of-two period length.
package pwmw_pkg;
    localparam int PWMW_SAMPLE_W = 10;   // sample width
    localparam int PWMW_PERIOD_W = 10;   // log2 of period length in clocks
    localparam int PWMW_DUTY_LO  = 155;  // high clocks at code 0
    localparam int PWMW_SPAN     = 776;  // extra high clocks at full code
endpackage

// File: rtl/pwmw_period_ctr.sv
// Free-running period counter with a registered period-start strobe.
// Assumes the period is 2**PERIOD_W clocks, so the counter wraps naturally.
module pwmw_period_ctr #(
    parameter int PERIOD_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic [PERIOD_W-1:0] cnt_q,
    output logic [PERIOD_W-1:0] cnt_next,
    output logic                wrap,
    output logic                start_o
);
    localparam logic [PERIOD_W-1:0] CNT_MAX = '1;

    // Next count and the end-of-period flag.
    always_comb begin
        cnt_next = cnt_q + 1'b1;
        wrap     = (cnt_q == CNT_MAX);
    end

    // Counter register and strobe aligned with counter value 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            start_o <= 1'b1;
        end else begin
            cnt_q   <= cnt_next;
            start_o <= (cnt_next == '0);
        end
    end

    // R2: counter advances by one every cycle
    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt_q == PERIOD_W'($past(cnt_q) + 1'b1)));
    // R6: strobe only at counter zero
    a_r6_strobe_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> (cnt_q == '0));
    // R6: strobe lasts one cycle
    a_r6_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);
endmodule

// File: rtl/pwmw_duty_scale.sv
// Affine map of an unsigned sample into the duty window:
// duty = LO + floor(sample * SPAN / (2**SAMPLE_W - 1)).
// Assumes LO + SPAN fits in DUTY_W bits. The divisor is a constant.
module pwmw_duty_scale #(
    parameter int SAMPLE_W = 10,
    parameter int DUTY_W   = 11,
    parameter int LO       = 155,
    parameter int SPAN     = 776
) (
    input  logic [SAMPLE_W-1:0] sample_i,
    output logic [DUTY_W-1:0]   duty_o
);
    localparam int FULL_CODE = (2 ** SAMPLE_W) - 1;
    localparam int PROD_W    = SAMPLE_W + $clog2(SPAN + 1);

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] quot;

    // Widened multiply, truncating divide, then add the window floor.
    always_comb begin
        prod   = PROD_W'(sample_i) * PROD_W'(SPAN);
        quot   = prod / PROD_W'(FULL_CODE);
        duty_o = DUTY_W'(LO) + DUTY_W'(quot);
    end

    // R3: scaled duty stays inside the window
    always_comb begin
        a_r3_scale_window: assert (duty_o >= DUTY_W'(LO) && duty_o <= DUTY_W'(LO + SPAN));
    end
endmodule

// File: rtl/pwmw_compare.sv
// Duty register loaded at period wrap, plus a registered comparator.
// Assumes cnt_next and wrap come from the period counter in the same cycle.
module pwmw_compare #(
    parameter int PERIOD_W = 10,
    parameter int DUTY_W   = 11,
    parameter int DUTY_RST = 543,
    parameter int LO       = 155,
    parameter int HI       = 931
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PERIOD_W-1:0] cnt_q,
    input  logic [PERIOD_W-1:0] cnt_next,
    input  logic                wrap,
    input  logic [DUTY_W-1:0]   duty_new,
    output logic                pwm_o
);
    logic [DUTY_W-1:0] duty_q;
    logic [DUTY_W-1:0] duty_next;

    // Duty value in force for the cycle being entered.
    always_comb begin
        duty_next = wrap ? duty_new : duty_q;
    end

    // Duty latch and the glitch-free output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_q <= DUTY_W'(DUTY_RST);
            pwm_o  <= 1'b1;
        end else begin
            duty_q <= duty_next;
            pwm_o  <= (DUTY_W'(cnt_next) < duty_next);
        end
    end

    // R4: duty reloads only after the counter-max cycle
    a_r4_hold_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(duty_q));
    // R3: latched duty within the window
    a_r3_duty_window: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_q >= DUTY_W'(LO)) && (duty_q <= DUTY_W'(HI)));
    // R5: high exactly while counter is below duty
    a_r5_high_below: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_o |-> (DUTY_W'(cnt_q) < duty_q));
    a_r5_low_above: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_o |-> (DUTY_W'(cnt_q) >= duty_q));
endmodule

// File: rtl/pwmw_dac.sv
// Top of the windowed PWM modulator: counter, scaler and comparator.
// Assumes the sample is synchronous to clk; it is sampled once per period.
module pwmw_dac
    import pwmw_pkg::*;
#(
    parameter int SAMPLE_W = PWMW_SAMPLE_W,
    parameter int PERIOD_W = PWMW_PERIOD_W,
    parameter int DUTY_LO  = PWMW_DUTY_LO,
    parameter int SPAN     = PWMW_SPAN
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] sample_i,
    output logic                pwm_o,
    output logic                period_start_o
);
    localparam int DUTY_W    = PERIOD_W + 1;
    localparam int FULL_CODE = (2 ** SAMPLE_W) - 1;
    localparam int MID_CODE  = 2 ** (SAMPLE_W - 1);
    localparam int DUTY_MID  = DUTY_LO + (MID_CODE * SPAN) / FULL_CODE;

    logic [PERIOD_W-1:0] cnt_q;
    logic [PERIOD_W-1:0] cnt_next;
    logic                wrap;
    logic [DUTY_W-1:0]   duty_new;

    pwmw_period_ctr #(.PERIOD_W(PERIOD_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_q    (cnt_q),
        .cnt_next (cnt_next),
        .wrap     (wrap),
        .start_o  (period_start_o)
    );

    pwmw_duty_scale #(
        .SAMPLE_W (SAMPLE_W),
        .DUTY_W   (DUTY_W),
        .LO       (DUTY_LO),
        .SPAN     (SPAN)
    ) u_scale (
        .sample_i (sample_i),
        .duty_o   (duty_new)
    );

    pwmw_compare #(
        .PERIOD_W (PERIOD_W),
        .DUTY_W   (DUTY_W),
        .DUTY_RST (DUTY_MID),
        .LO       (DUTY_LO),
        .HI       (DUTY_LO + SPAN)
    ) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_q    (cnt_q),
        .cnt_next (cnt_next),
        .wrap     (wrap),
        .duty_new (duty_new),
        .pwm_o    (pwm_o)
    );

    // R7: reset state seen at the ports
    a_r7_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (pwm_o && period_start_o));
endmodule

// File: tb/pwmw_dac_tb_top.sv
// Directed bench: each task drives one scenario and checks whole periods.
module pwmw_dac_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] sample_i = '0;
    logic       pwm_o;
    logic       period_start_o;

    int    n_checks = 0;
    int    n_fail   = 0;
    int    cur_exp  = 543;
    string cur_tag  = "R7";
    bit    done     = 1'b0;

    always #4 clk = ~clk;

    pwmw_dac dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .sample_i       (sample_i),
        .pwm_o          (pwm_o),
        .period_start_o (period_start_o)
    );

    function automatic int exp_duty(int s);
        return 155 + (s * 776) / 1023;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Observe one period from its start; optionally change the sample at cycle chg_at.
    task automatic measure(int exp, string tag, int chg_at, int chg_val);
        int hi = 0, shape_bad = 0, strobe_bad = 0;
        for (int i = 0; i < 1024; i++) begin
            if (i == chg_at) sample_i = 10'(chg_val);
            hi += int'(pwm_o);
            if (pwm_o != (i < exp)) shape_bad++;
            if (period_start_o != (i == 0)) strobe_bad++;
            @(negedge clk);
        end
        check({tag, " high count (R1)"}, hi, exp);
        check("R5 single pulse shape errors", shape_bad, 0);
        check("R6 strobe placement errors", strobe_bad, 0);
        check("R2 strobe after 1024 cycles", int'(period_start_o), 1);
    endtask

    // Present a code for the next period while checking the current one.
    task automatic run_code(int s, string tag);
        sample_i = 10'(s);
        measure(cur_exp, cur_tag, -1, 0);
        cur_exp = exp_duty(s);
        cur_tag = tag;
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        sample_i = 10'd1023;
        repeat (3) @(negedge clk);
        check("R7 pwm during reset", int'(pwm_o), 1);
        check("R7 strobe during reset", int'(period_start_o), 1);
        rst_n = 1'b1;
        cur_exp = 543;
        cur_tag = "R7";
    endtask

    task automatic test_bounds();
        run_code(1023, "R3 top code");
        run_code(0, "R3 bottom code");
        run_code(1, "R1 code 1");
        run_code(512, "R1 mid code");
    endtask

    task automatic test_patterns();
        run_code(2, "R1 code 2");
        run_code(100, "R1 code 100");
        run_code(767, "R1 code 767");
        run_code(1022, "R1 code 1022");
    endtask

    task automatic test_midchange();
        run_code(200, "R4 before change");
        // Change at cycle 300 must not touch the pulse now playing.
        measure(cur_exp, "R4 mid-period change", 300, 900);
        cur_exp = exp_duty(900);
        cur_tag = "R4 taken at wrap";
        // Change in the counter-1023 cycle decides the next period.
        measure(cur_exp, cur_tag, 1023, 40);
        cur_exp = exp_duty(40);
        cur_tag = "R4 last-cycle change";
        sample_i = 10'd40;
        measure(cur_exp, cur_tag, -1, 0);
    endtask

    initial begin
        @(negedge clk);
        test_reset();
        sample_i = 10'd0;
        measure(543, "R7 first period", -1, 0);
        cur_exp = exp_duty(0);
        cur_tag = "R1 code 0";
        test_bounds();
        test_patterns();
        test_midchange();
        // Reset in mid-run returns to the centre of the window.
        repeat (123) @(negedge clk);
        test_reset();
        measure(543, "R7 after re-reset", -1, 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule